// File: doc/BRIEF.md
# Compressed Floating-Point Load/Store Expander

This block is a purely combinational front-end stage for an instruction decoder. It watches one 16-bit compressed instruction and finds the eight compressed floating-point memory forms among them. These are loads and stores of single and double precision, each in two kinds: relative to the stack pointer, or relative to a register from the compressed register window. For a matching form it emits the equivalent full-length 32-bit floating-point load or store word and raises a valid flag.

Each form packs its unsigned offset into the instruction bits in its own order, and each has its own scale. The expander unscrambles the offset, widens the register fields and builds the standard 32-bit encoding. A match counts only when the extensions it needs are switched on and the selected register width allows it. In every other case valid stays low and the output word is all zero. Other stages handle integer compressed forms, execution and exceptions.

Top module: `cfpx_expander`

## Requirements
- R1: Input funct3 `instr_i[15:13]`=001 with quadrant `instr_i[1:0]`=10 is a double load from the stack pointer. The destination is `instr_i[11:7]` and the base register is x2. The byte offset takes bits [8:6] from `instr_i[4:2]`, bit 5 from `instr_i[12]` and bits [4:3] from `instr_i[6:5]`, and its bits [2:0] are zero.
- R2: funct3 101 with quadrant 10 is a double store to the stack pointer. The source is `instr_i[6:2]` and the base is x2. The offset takes bits [8:6] from `instr_i[9:7]` and bits [5:3] from `instr_i[12:10]`, and its bits [2:0] are zero.
- R3: In quadrant 00, funct3 001 is a double load and funct3 101 is a double store, both register-relative. The base is x(8+`instr_i[9:7]`) and the data register is x(8+`instr_i[4:2]`). The offset takes bits [7:6] from `instr_i[6:5]` and bits [5:3] from `instr_i[12:10]`, and its bits [2:0] are zero.
- R4: funct3 011 with quadrant 10 is a single load from the stack pointer. The destination is `instr_i[11:7]` and the base is x2. The offset takes bits [7:6] from `instr_i[3:2]`, bit 5 from `instr_i[12]` and bits [4:2] from `instr_i[6:4]`, and its bits [1:0] are zero.
- R5: funct3 111 with quadrant 10 is a single store to the stack pointer. The source is `instr_i[6:2]` and the base is x2. The offset takes bits [7:6] from `instr_i[8:7]` and bits [5:2] from `instr_i[12:9]`, and its bits [1:0] are zero.
- R6: In quadrant 00, funct3 011 is a single load and funct3 111 is a single store, both register-relative. Base and data registers are as in R3. The offset takes bit 6 from `instr_i[5]`, bits [5:3] from `instr_i[12:10]` and bit 2 from `instr_i[6]`, and its bits [1:0] are zero.
- R7: The output word uses opcode 0000111 for loads, laid out as {off[11:0], base, width, dest, opcode}. Stores use opcode 0100111, laid out as {off[11:5], src, base, width, off[4:0], opcode}. The width field is 011 for double and 010 for single. The offset is zero-extended to 12 bits.
- R8: Single forms (R4 to R6) are recognized only when `ena_comp_i` and `ena_sp_i` are both high and `xlen_sel_i`=01, which selects 32-bit.
- R9: Double forms (R1 to R3) are recognized only when `ena_comp_i` and `ena_dp_i` are both high and `xlen_sel_i` is 01 (32-bit) or 10 (64-bit). The codes 00 and 11 block them.
- R10: Any encoding that is not one of these forms, or that R8 or R9 blocks, gives `valid_o`=0 and `word_o`=0. Examples are quadrant 11 and funct3 000, 010, 100 or 110.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 16 | Compressed instruction under test |
| xlen_sel_i | input | 2 | Register width code: 01 = 32-bit, 10 = 64-bit, others unsupported |
| ena_comp_i | input | 1 | Compressed base extension enabled |
| ena_sp_i | input | 1 | Single-precision float enabled |
| ena_dp_i | input | 1 | Double-precision float enabled |
| valid_o | output | 1 | High when a recognized form is expanded |
| word_o | output | 32 | Expanded 32-bit instruction, zero when not valid |

## Verification
Both results are combinational, so `valid_o` and `word_o` are due in the same cycle as the instruction and enables that produce them, with no register on the path. The driver changes inputs on the rising edge and queues the expected pair. The monitor pops that entry on the next falling edge, half a period later, when the inputs have long settled and are still held. Expected words come from the offset value and register numbers the driver chose. The bench builds the compressed input from them in the encoding direction, so the design's decoding direction is never reused.

// File: rtl/cfpx_pkg.sv
package cfpx_pkg;

  localparam int CW    = 16;
  localparam int XW    = 32;
  localparam int IMMW  = 12;
  localparam int RW    = 5;
  localparam int CRW   = 3;
  localparam int NFORM = 8;

  localparam logic [6:0]    OPC_FLOAD  = 7'b0000111;
  localparam logic [6:0]    OPC_FSTORE = 7'b0100111;
  localparam logic [2:0]    WID_DBL    = 3'b011;
  localparam logic [2:0]    WID_SGL    = 3'b010;
  localparam logic [1:0]    XL32       = 2'b01;
  localparam logic [1:0]    XL64       = 2'b10;
  localparam logic [RW-1:0] SP_REG     = 5'd2;

  // order matters: odd index = store, index < 4 = double
  typedef enum logic [2:0] {
    F_DLSP, F_DSSP, F_DLR, F_DSR, F_SLSP, F_SSSP, F_SLR, F_SSR
  } form_e;

  typedef struct packed {
    logic [IMMW-1:0] imm;
    logic [RW-1:0]   base;
    logic [RW-1:0]   data;
    logic            store;
    logic            dbl;
  } fields_t;

  function automatic logic form_is_store(form_e f);
    return f inside {F_DSSP, F_DSR, F_SSSP, F_SSR};
  endfunction

  function automatic logic form_is_dbl(form_e f);
    return f inside {F_DLSP, F_DSSP, F_DLR, F_DSR};
  endfunction

  function automatic logic form_is_sp(form_e f);
    return f inside {F_DLSP, F_DSSP, F_SLSP, F_SSSP};
  endfunction

  function automatic logic [2:0] form_f3(form_e f);
    case (f)
      F_DLSP, F_DLR: return 3'b001;
      F_DSSP, F_DSR: return 3'b101;
      F_SLSP, F_SLR: return 3'b011;
      default:       return 3'b111;
    endcase
  endfunction

  function automatic logic [1:0] form_quad(form_e f);
    return form_is_sp(f) ? 2'b10 : 2'b00;
  endfunction

  function automatic logic [RW-1:0] creg(logic [CRW-1:0] n);
    return {2'b01, n};
  endfunction

  // body holds instruction bits 12..2
  function automatic fields_t form_fields(form_e f, logic [12:2] b);
    fields_t r;
    r       = '0;
    r.base  = form_is_sp(f) ? SP_REG : creg(b[9:7]);
    r.data  = form_is_sp(f) ? (form_is_store(f) ? b[6:2] : b[11:7]) : creg(b[4:2]);
    r.store = form_is_store(f);
    r.dbl   = form_is_dbl(f);
    case (f)
      F_DLSP:       r.imm = {3'b000, b[4:2], b[12], b[6:5], 3'b000};
      F_DSSP:       r.imm = {3'b000, b[9:7], b[12:10], 3'b000};
      F_DLR, F_DSR: r.imm = {4'b0000, b[6:5], b[12:10], 3'b000};
      F_SLSP:       r.imm = {4'b0000, b[3:2], b[12], b[6:4], 2'b00};
      F_SSSP:       r.imm = {4'b0000, b[8:7], b[12:9], 2'b00};
      default:      r.imm = {5'b00000, b[5], b[12:10], b[6], 2'b00};
    endcase
    return r;
  endfunction

  function automatic logic [XW-1:0] pack_word(fields_t r);
    logic [2:0] wid;
    wid = r.dbl ? WID_DBL : WID_SGL;
    if (r.store)
      return {r.imm[11:5], r.data, r.base, wid, r.imm[4:0], OPC_FSTORE};
    return {r.imm, r.base, wid, r.data, OPC_FLOAD};
  endfunction

endpackage

// File: rtl/cfpx_match.sv
module cfpx_match
  import cfpx_pkg::*;
#(
  parameter int N = NFORM
) (
  input  logic [2:0]   f3_i,
  input  logic [1:0]   quad_i,
  output logic [N-1:0] hit_o
);
  for (genvar gi = 0; gi < N; gi++) begin : g_form
    localparam form_e FF = form_e'(gi);
    assign hit_o[gi] = (f3_i == form_f3(FF)) && (quad_i == form_quad(FF));
  end
endmodule

// File: rtl/cfpx_gate.sv
module cfpx_gate
  import cfpx_pkg::*;
(
  input  logic [1:0] xlen_sel_i,
  input  logic       ena_comp_i,
  input  logic       ena_sp_i,
  input  logic       ena_dp_i,
  output logic       sp_ok_o,
  output logic       dp_ok_o
);
  logic xl32, xl64;
  assign xl32    = (xlen_sel_i == XL32);
  assign xl64    = (xlen_sel_i == XL64);
  assign sp_ok_o = ena_comp_i & ena_sp_i & xl32;
  assign dp_ok_o = ena_comp_i & ena_dp_i & (xl32 | xl64);
endmodule

// File: rtl/cfpx_select.sv
module cfpx_select
  import cfpx_pkg::*;
#(
  parameter int N = NFORM
) (
  input  logic [12:2]  body_i,
  input  logic [N-1:0] ok_i,
  output fields_t      sel_o
);
  fields_t fld [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_fld
    assign fld[gi] = form_fields(form_e'(gi), body_i);
  end

  always_comb begin
    sel_o = '0;
    for (int i = 0; i < N; i++)
      if (ok_i[i]) sel_o = sel_o | fld[i];
  end
endmodule

// File: rtl/cfpx_expander.sv
module cfpx_expander
  import cfpx_pkg::*;
(
  input  logic [15:0] instr_i,
  input  logic [1:0]  xlen_sel_i,
  input  logic        ena_comp_i,
  input  logic        ena_sp_i,
  input  logic        ena_dp_i,
  output logic        valid_o,
  output logic [31:0] word_o
);
  logic [NFORM-1:0] form_hit;
  logic [NFORM-1:0] form_ok;
  logic             sp_ok, dp_ok;
  fields_t          sel;

  cfpx_match #(.N(NFORM)) u_match (
    .f3_i   (instr_i[15:13]),
    .quad_i (instr_i[1:0]),
    .hit_o  (form_hit)
  );

  cfpx_gate u_gate (
    .xlen_sel_i (xlen_sel_i),
    .ena_comp_i (ena_comp_i),
    .ena_sp_i   (ena_sp_i),
    .ena_dp_i   (ena_dp_i),
    .sp_ok_o    (sp_ok),
    .dp_ok_o    (dp_ok)
  );

  for (genvar gi = 0; gi < NFORM; gi++) begin : g_ok
    localparam logic IS_D = form_is_dbl(form_e'(gi));
    assign form_ok[gi] = form_hit[gi] & (IS_D ? dp_ok : sp_ok);
  end

  cfpx_select #(.N(NFORM)) u_sel (
    .body_i (instr_i[12:2]),
    .ok_i   (form_ok),
    .sel_o  (sel)
  );

  assign valid_o = |form_ok;
  assign word_o  = valid_o ? pack_word(sel) : '0;
endmodule

// File: rtl/cfpx_expander_chk.sv
module cfpx_expander_chk (
  input logic [15:0] instr_i,
  input logic [1:0]  xlen_sel_i,
  input logic        ena_comp_i,
  input logic        ena_sp_i,
  input logic        ena_dp_i,
  input logic        valid_o,
  input logic [31:0] word_o,
  input logic [7:0]  form_hit,
  input logic        sp_ok,
  input logic        dp_ok
);
  always_comb begin
    // R10
    not_recognized_zero_chk: assert (valid_o || word_o == 32'd0)
      else $error("word nonzero while not valid");
    // R10
    hit_onehot_chk: assert ($onehot0(form_hit))
      else $error("more than one form matched");
    // R10
    quad_legal_chk: assert (!valid_o || instr_i[1:0] != 2'b11)
      else $error("valid from quadrant 11");
    // R7
    opcode_legal_chk: assert (!valid_o || word_o[6:0] == 7'b0000111 || word_o[6:0] == 7'b0100111)
      else $error("illegal output opcode");
    // R8
    single_gate_chk: assert (!(valid_o && word_o[14:12] == 3'b010) ||
                             (ena_comp_i && ena_sp_i && xlen_sel_i == 2'b01 && sp_ok))
      else $error("single form let through");
    // R9
    double_gate_chk: assert (!(valid_o && word_o[14:12] == 3'b011) ||
                             (ena_comp_i && ena_dp_i && dp_ok &&
                              (xlen_sel_i == 2'b01 || xlen_sel_i == 2'b10)))
      else $error("double form let through");
    // R1
    dbl_load_align_chk: assert (!(valid_o && word_o[6:0] == 7'b0000111 && word_o[14:12] == 3'b011) ||
                                word_o[22:20] == 3'b000)
      else $error("double load offset misaligned");
    // R2
    dbl_store_align_chk: assert (!(valid_o && word_o[6:0] == 7'b0100111 && word_o[14:12] == 3'b011) ||
                                 word_o[9:7] == 3'b000)
      else $error("double store offset misaligned");
    // R4
    sgl_load_align_chk: assert (!(valid_o && word_o[6:0] == 7'b0000111 && word_o[14:12] == 3'b010) ||
                                word_o[21:20] == 2'b00)
      else $error("single load offset misaligned");
    // R3
    creg_window_chk: assert (!(valid_o && instr_i[1:0] == 2'b00) || word_o[19:18] == 2'b01)
      else $error("register-relative base outside x8..x15");
    // R5
    sp_base_chk: assert (!(valid_o && instr_i[1:0] == 2'b10) || word_o[19:15] == 5'd2)
      else $error("stack-pointer form base not x2");
  end
endmodule

bind cfpx_expander cfpx_expander_chk u_chk (
  .instr_i    (instr_i),
  .xlen_sel_i (xlen_sel_i),
  .ena_comp_i (ena_comp_i),
  .ena_sp_i   (ena_sp_i),
  .ena_dp_i   (ena_dp_i),
  .valid_o    (valid_o),
  .word_o     (word_o),
  .form_hit   (form_hit),
  .sp_ok      (sp_ok),
  .dp_ok      (dp_ok)
);

// File: tb/sim_cfpx_expander.sv
module sim_cfpx_expander;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr;
  logic [1:0]  xl;
  logic        en_c, en_f, en_d;
  logic        valid;
  logic [31:0] word;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  typedef struct {
    logic        v;
    logic [31:0] w;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfpx_expander u0 (
    .instr_i    (instr),
    .xlen_sel_i (xl),
    .ena_comp_i (en_c),
    .ena_sp_i   (en_f),
    .ena_dp_i   (en_d),
    .valid_o    (valid),
    .word_o     (word)
  );

  // monitor: results are combinational, sampled half a period after drive
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (valid !== e.v || word !== e.w) begin
        n_fail++;
        $display("FAIL %s: got valid=%0d word=%h, expected valid=%0d word=%h",
                 e.tag, valid, word, e.v, e.w);
      end
    end
  end

  task automatic drive(input logic [15:0] c, input logic [1:0] x, input logic ec,
                       input logic ef, input logic ed, input logic ev,
                       input logic [31:0] ew, input string tag);
    exp_t e;
    @(posedge clk);
    instr = c; xl = x; en_c = ec; en_f = ef; en_d = ed;
    e.v = ev; e.w = ev ? ew : 32'd0; e.tag = tag;
    sb.push_back(e);
  endtask

  // encode a compressed form from a plain offset and register numbers
  function automatic logic [15:0] mk16(int f, int offv, int r5, int ca, int cb);
    logic [11:0] o;
    logic [4:0]  r;
    logic [2:0]  a, b;
    o = offv[11:0]; r = r5[4:0]; a = ca[2:0]; b = cb[2:0];
    case (f)
      0: return {3'b001, o[5], r, o[4:3], o[8:6], 2'b10};
      1: return {3'b101, o[5:3], o[8:6], r, 2'b10};
      2: return {3'b001, o[5:3], a, o[7:6], b, 2'b00};
      3: return {3'b101, o[5:3], a, o[7:6], b, 2'b00};
      4: return {3'b011, o[5], r, o[4:2], o[7:6], 2'b10};
      5: return {3'b111, o[5:2], o[7:6], r, 2'b10};
      6: return {3'b011, o[5:3], a, o[2], o[6], b, 2'b00};
      default: return {3'b111, o[5:3], a, o[2], o[6], b, 2'b00};
    endcase
  endfunction

  function automatic logic [31:0] mk32(int f, int offv, int r5, int ca, int cb);
    int base, dat, wid, w;
    bit sp, st;
    sp   = (f == 0 || f == 1 || f == 4 || f == 5);
    st   = (f % 2) == 1;
    base = sp ? 2 : 8 + ca;
    dat  = sp ? r5 : 8 + cb;
    wid  = (f < 4) ? 3 : 2;
    if (st)
      w = ((offv / 32) << 25) + (dat << 20) + (base << 15) + (wid << 12) +
          ((offv % 32) << 7) + 39;
    else
      w = (offv << 20) + (base << 15) + (wid << 12) + (dat << 7) + 7;
    return w[31:0];
  endfunction

  function automatic int off_max(int f);
    case (f)
      0, 1:    return 504;
      2, 3:    return 248;
      4, 5:    return 252;
      default: return 124;
    endcase
  endfunction

  function automatic string rtag(int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R6";
    endcase
  endfunction

  initial begin
    instr = '0; xl = 2'b01; en_c = 1'b0; en_f = 1'b0; en_d = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // reset state: all-zero inputs are no form (R10)
    drive(16'h0000, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 32'd0, "R10 reset idle");

    // main function, every form, offsets zero, max and random (R1..R7)
    for (int f = 0; f < 8; f++) begin
      for (int k = 0; k < 10; k++) begin
        int scale, offv, r5, ca, cb;
        logic [1:0] x;
        scale = (f < 4) ? 8 : 4;
        offv  = (k == 0) ? 0 : (k == 1) ? off_max(f) :
                scale * ($urandom % (off_max(f) / scale + 1));
        r5 = (k == 1) ? 31 : $urandom % 32;
        ca = (k == 1) ? 7 : $urandom % 8;
        cb = (k == 1) ? 7 : $urandom % 8;
        x  = (f < 4 && k % 2 == 1) ? 2'b10 : 2'b01;
        drive(mk16(f, offv, r5, ca, cb), x, 1'b1, 1'b1, 1'b1, 1'b1,
              mk32(f, offv, r5, ca, cb), {rtag(f), " R7 expand"});
      end
    end

    // gating: each enable cleared and unsupported width codes (R8, R9)
    for (int f = 0; f < 8; f++) begin
      logic [15:0] c;
      logic [31:0] w;
      string t;
      c = mk16(f, (f < 4) ? 40 : 20, 5, 3, 4);
      w = mk32(f, (f < 4) ? 40 : 20, 5, 3, 4);
      t = (f < 4) ? "R9" : "R8";
      drive(c, 2'b01, 1'b0, 1'b1, 1'b1, 1'b0, 0, {t, " compressed off"});
      drive(c, 2'b01, 1'b1, (f < 4), (f >= 4), 1'b0, 0, {t, " own float off"});
      drive(c, 2'b01, 1'b1, (f >= 4), (f < 4), 1'b1, w, {t, " other float off"});
      drive(c, 2'b10, 1'b1, 1'b1, 1'b1, (f < 4), w, {t, " width 64"});
      drive(c, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 0, {t, " width code 11"});
      drive(c, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 0, {t, " width code 00"});
    end

    // non-matching encodings (R10)
    for (int k = 0; k < 8; k++) begin
      logic [15:0] c;
      c = 16'($urandom);
      drive({c[15:2], 2'b11}, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 0, "R10 quadrant 11");
      drive({k[1:0], 1'b0, c[12:2], 1'b0, k[2]}, 2'b01, 1'b1, 1'b1, 1'b1,
            1'b0, 0, "R10 even funct3");
    end

    @(posedge clk);
    @(negedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < WATCHDOG) begin
      @(posedge clk);
      cycles++;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got %0d cycles, expected under %0d", cycles, WATCHDOG);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule